// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block takes an N-bit word carried on two wires per bit and tells the surrounding logic two things. It reports when the whole word has become valid. It also reports when the whole word has gone back to the empty (spacer) state. Each bit is judged from its own pair of wires, so no separate strobe is needed.

Per-bit presence is the OR of the two wires. The presence signals are merged by a balanced tree of state-holding consensus cells (C-elements). Each cell follows its inputs when they agree and keeps its last output when they differ. Because of this, the completion output has hysteresis. The cells are modelled as hold registers on a sampling clock.

The valid word is also decoded to plain binary. A pair with both wires high is not a legal code, and it raises a flag that stays set until reset.

The producer is expected to obey the alternation valid word, spacer, valid word. Within one phase, bits may arrive or leave in any order and at any time.

Top module: `dr_done_detect`

## Requirements
- R1: Each bit i is coded on {rail1_i[i], rail0_i[i]}. 2'b01 is logic 0, 2'b10 is logic 1, 2'b00 is the spacer (no data), and 2'b11 is illegal.
- R2: done_o rises on the clock edge after the first sampled cycle in which every bit is non-spacer. It never rises while any bit is still spacer.
- R3: done_o falls on the clock edge after the first sampled cycle in which every bit is spacer. It never falls while any bit still carries a code.
- R4: While the word is mixed (some bits present, some spacer) and the alternation is obeyed, done_o keeps its previous value, whatever order the bits change in.
- R5: Any bit sampled at 2'b11 sets illegal_o on the next edge. illegal_o then stays high until rst_ni is asserted.
- R6: While data_valid_o is high, data_o equals rail1_i as sampled on the previous edge. data_valid_o equals done_o. While data_valid_o is low, data_o is all zeros.
- R7: While rst_ni is low, done_o, data_valid_o, illegal_o and data_o are all zero, and every consensus cell is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock for the hold cells |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rail0_i | input | WIDTH | Low rail of each bit (high means logic 0) |
| rail1_i | input | WIDTH | High rail of each bit (high means logic 1) |
| done_o | output | 1 | Word complete; has hysteresis |
| data_o | output | WIDTH | Decoded binary word, zero when not valid |
| data_valid_o | output | 1 | data_o holds a complete word |
| illegal_o | output | 1 | Sticky flag for a both-rails-high code |

## Verification
Words are applied with their bits arriving one per cycle in a shuffled order, and then leaving in a fresh shuffled order. These runs separate a correct tree from one that fires on a partial word or releases before the last bit has left. Words that arrive all in one cycle, together with the all-zeros and all-ones values, separate the rail decoding from the completion logic. A final pass drives one bit to both rails high among spacers. It confirms that the flag is raised, that it survives the return to spacer, and that done_o stays low.

// File: rtl/dr_pkg.sv
package dr_pkg;
  // pair code as {rail1, rail0}
  typedef enum logic [1:0] {
    DR_NULL = 2'b00,
    DR_ZERO = 2'b01,
    DR_ONE  = 2'b10,
    DR_BAD  = 2'b11
  } dr_code_e;

  function automatic int unsigned pow2_ceil(int unsigned n);
    int unsigned p;
    p = 1;
    while (p < n) p = p << 1;
    return p;
  endfunction
endpackage

// File: rtl/dr_bit_classify.sv
module dr_bit_classify
  import dr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] rail0_i,
  input  logic [WIDTH-1:0] rail1_i,
  output logic [WIDTH-1:0] present_o,
  output logic [WIDTH-1:0] bad_o,
  output logic [WIDTH-1:0] value_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    dr_code_e code;
    assign code = dr_code_e'({rail1_i[i], rail0_i[i]});
    always_comb begin
      present_o[i] = 1'b1;
      bad_o[i]     = 1'b0;
      value_o[i]   = 1'b0;
      unique case (code)
        DR_NULL: present_o[i] = 1'b0;
        DR_ZERO: value_o[i]   = 1'b0;
        DR_ONE:  value_o[i]   = 1'b1;
        DR_BAD:  begin bad_o[i] = 1'b1; value_o[i] = 1'b1; end
        default: present_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/dr_c_elem.sv
module dr_c_elem (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic z_o
);
  logic held_q;

  // follow on agreement, otherwise keep last value
  assign z_o = (a_i == b_i) ? a_i : held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= 1'b0;
    else         held_q <= z_o;
  end
endmodule

// File: rtl/dr_c_tree.sv
module dr_c_tree
  import dr_pkg::*;
#(
  parameter int unsigned LEAVES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LEAVES-1:0] leaf_i,
  output logic              root_o
);
  localparam int unsigned PADDED = pow2_ceil(LEAVES);
  localparam int unsigned NODES  = 2 * PADDED - 1;

  logic [NODES-1:0] node;

  // pad slots copy leaf 0 so they never change the consensus
  for (genvar j = 0; j < PADDED; j++) begin : g_leaf
    if (j < LEAVES) begin : g_real
      assign node[PADDED-1+j] = leaf_i[j];
    end else begin : g_pad
      assign node[PADDED-1+j] = leaf_i[0];
    end
  end

  if (PADDED == 1) begin : g_single
    dr_c_elem u_cel (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .a_i   (leaf_i[0]),
      .b_i   (leaf_i[0]),
      .z_o   (root_o)
    );
  end else begin : g_tree
    for (genvar k = 0; k < PADDED - 1; k++) begin : g_node
      dr_c_elem u_cel (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .a_i   (node[2*k+1]),
        .b_i   (node[2*k+2]),
        .z_o   (node[k])
      );
    end
    assign root_o = node[0];
  end
endmodule

// File: rtl/dr_done_detect.sv
module dr_done_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] rail0_i,
  input  logic [WIDTH-1:0] rail1_i,
  output logic             done_o,
  output logic [WIDTH-1:0] data_o,
  output logic             data_valid_o,
  output logic             illegal_o
);
  logic [WIDTH-1:0] present, bad, value;
  logic             root;
  logic             done_q, illegal_q;
  logic [WIDTH-1:0] data_q;

  dr_bit_classify #(.WIDTH(WIDTH)) u_classify (
    .rail0_i  (rail0_i),
    .rail1_i  (rail1_i),
    .present_o(present),
    .bad_o    (bad),
    .value_o  (value)
  );

  dr_c_tree #(.LEAVES(WIDTH)) u_tree (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .leaf_i(present),
    .root_o(root)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      data_q    <= '0;
    end else begin
      done_q    <= root;
      illegal_q <= illegal_q | (|bad);
      data_q    <= value;
    end
  end

  assign done_o       = done_q;
  assign data_valid_o = done_q;
  assign data_o       = done_q ? data_q : '0;
  assign illegal_o    = illegal_q;
endmodule

// File: rtl/dr_done_detect_chk.sv
module dr_done_detect_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] rail0_i,
  input logic [WIDTH-1:0] rail1_i,
  input logic             done_o,
  input logic [WIDTH-1:0] data_o,
  input logic             data_valid_o,
  input logic             illegal_o
);
  p_rise_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(&(rail0_i | rail1_i)));

  p_fall_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> $past((rail0_i | rail1_i) == '0));

  p_bad_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(rail0_i & rail1_i)) |=> illegal_o);

  p_bad_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o);

  p_data_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_valid_o |-> (data_o == '0));

  p_data_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> (data_o == $past(rail1_i)));

  p_valid_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o == done_o);

  // R7: outputs cleared while reset is held
  always_comb begin
    if (!rst_ni) begin
      a_reset_r7: assert (!done_o && !illegal_o && !data_valid_o && data_o == '0);
    end
  end
endmodule

bind dr_done_detect dr_done_detect_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rail0_i     (rail0_i),
  .rail1_i     (rail1_i),
  .done_o      (done_o),
  .data_o      (data_o),
  .data_valid_o(data_valid_o),
  .illegal_o   (illegal_o)
);

// File: tb/dr_done_detect_bench.sv
module dr_done_detect_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] r0 = '0, r1 = '0;
  logic         done, dvalid, illegal;
  logic [W-1:0] data;

  int     checks = 0, errors = 0;
  bit     finished = 0;
  string  tag = "R7";

  // behavioural reference
  logic         m_done, m_ill;
  logic [W-1:0] m_data;

  always #5 clk = ~clk;

  dr_done_detect #(.WIDTH(W)) u_dr_done_detect (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rail0_i     (r0),
    .rail1_i     (r1),
    .done_o      (done),
    .data_o      (data),
    .data_valid_o(dvalid),
    .illegal_o   (illegal)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_done <= 1'b0; m_ill <= 1'b0; m_data <= '0;
    end else begin
      if ((r0 | r1) == {W{1'b1}}) m_done <= 1'b1;
      else if ((r0 | r1) == '0)   m_done <= 1'b0;
      m_data <= r1;
      m_ill  <= m_ill | ((r0 & r1) != '0);
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("done", 32'(done), 32'(m_done));
    chk("R6 data_valid", 32'(dvalid), 32'(m_done));
    chk("R1 R6 data", 32'(data), 32'(m_done ? m_data : '0));
    chk("R5 illegal", 32'(illegal), 32'(m_ill));
  endtask

  task automatic set_bit(input int k, input logic v);
    r0[k] = ~v;
    r1[k] = v;
  endtask

  task automatic shuffle(ref int ord[W]);
    for (int i = 0; i < W; i++) ord[i] = i;
    for (int i = W - 1; i > 0; i--) begin
      int j = $urandom_range(i, 0);
      int t = ord[i];
      ord[i] = ord[j];
      ord[j] = t;
    end
  endtask

  task automatic run_word(input logic [W-1:0] w, input bit at_once);
    int ord[W];
    tag = "R2 R4";
    if (at_once) begin
      r1 = w; r0 = ~w;
      step();
    end else begin
      shuffle(ord);
      for (int i = 0; i < W; i++) begin
        set_bit(ord[i], w[ord[i]]);
        step();
      end
    end
    step();
    step();
    tag = "R3 R4";
    shuffle(ord);
    for (int i = 0; i < W; i++) begin
      r0[ord[i]] = 1'b0;
      r1[ord[i]] = 1'b0;
      step();
    end
    step();
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R7";
    chk("reset done", 32'(done), 0);
    chk("reset illegal", 32'(illegal), 0);
    chk("reset data_valid", 32'(dvalid), 0);
    chk("reset data", 32'(data), 0);
    rst_n = 1'b1;
    step();
    run_word('0, 1'b0);
    run_word('1, 1'b0);
    run_word(8'hA5, 1'b1);
    run_word('1, 1'b1);
    for (int n = 0; n < 20; n++) run_word(W'($urandom), 1'b0);
    tag = "R5";
    r0[3] = 1'b1; r1[3] = 1'b1;
    step();
    step();
    r0[3] = 1'b0; r1[3] = 1'b0;
    repeat (3) step();
    chk("R5 flag kept", 32'(illegal), 1);
    chk("R2 done low after bad code", 32'(done), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule